// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by fetching one translation entry from a table in memory. A request's virtual address is split into a page number (upper bits) and a byte offset within the page (lower bits), with a power-of-two page size. Two context registers describe the active table: the table base, which is the memory address of entry zero, and the table length, which is the number of entries the current address space owns. The operating software rewrites both at a context switch. Pointing the walker at a different address space needs nothing more than a new base value.

For each request the walker first compares the page number against the table length. An out-of-range page ends in a trap with no memory access. An in-range page causes exactly one read, at base plus page number, over a simple read port whose data can arrive any number of cycles later. The returned entry carries a valid flag and a frame number. An invalid entry ends in a trap. A valid entry yields the physical address: the frame number joined to the unchanged offset. Only one request is in flight at a time, and each response is a single-cycle pulse.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready_o` is 1, `rsp_valid_o` is 0 and `mem_rd_o` is 0. Base and length reset to 0, so any request before the first context load traps with cause 2'b01.
- R2: With default parameters, bits 11:0 of `req_vaddr_i` are the page offset and bits 31:12 are the page number.
- R3: When `ctx_load_i` is high at a rising clock edge, base and length take `ctx_base_i` and `ctx_len_i`, and later requests use them. Changing only the base redirects the entry read for the same page number to a different memory word.
- R4: A page number greater than or equal to the length makes a response with `rsp_trap_o`=1, `rsp_cause_o`=2'b01 and `rsp_paddr_o`=0. No `mem_rd_o` pulse is issued, and `rsp_valid_o` is high in the second cycle after the accepting edge.
- R5: An in-range page number makes exactly one single-cycle `mem_rd_o` pulse, in the cycle after the accepting edge, with `mem_addr_o` equal to base plus page number. The table is indexed one entry per memory word.
- R6: In an entry, bit 0 is the valid flag and bits 31:12 are the frame number. A returned entry with bit 0 clear makes a response with `rsp_trap_o`=1, `rsp_cause_o`=2'b10 and `rsp_paddr_o`=0.
- R7: A returned entry with bit 0 set makes a response with `rsp_trap_o`=0, `rsp_cause_o`=2'b00 and `rsp_paddr_o` equal to {frame number, offset}. `rsp_valid_o` is high in the cycle after the edge on which `mem_rvalid_i` is sampled high.
- R8: A request is accepted only when `req_valid_i` and `req_ready_o` are both high at an edge. `req_ready_o` is high only while no request is in flight. A `req_valid_i` seen while `req_ready_o` is low produces no read and no response.
- R9: `rsp_valid_o` is high for exactly one cycle per accepted request, and `req_ready_o` is high in the cycle after it.
- R10: A `mem_rvalid_i` pulse while no entry read is outstanding is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctx_load_i | input | 1 | Load base and length registers |
| ctx_base_i | input | 32 | New table base (word address of entry 0) |
| ctx_len_i | input | 21 | New table length in entries |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| mem_rd_o | output | 1 | Entry read strobe, one cycle |
| mem_addr_o | output | 32 | Entry word address |
| mem_rvalid_i | input | 1 | Entry data valid |
| mem_rdata_i | input | 32 | Entry data |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_paddr_o | output | 32 | Physical address, 0 on trap |
| rsp_trap_o | output | 1 | Translation trapped |
| rsp_cause_o | output | 2 | 2'b01 length violation, 2'b10 invalid entry, 2'b00 none |

## Verification
On every cycle the assertions check the following properties:
- responses and read strobes last one cycle;
- a length trap is never preceded by a read strobe;
- the walker drops ready after it accepts a request;
- a stray read-valid pulse while idle produces no response;
- a successful response keeps the request's offset;
- the cause code matches the trap flag, and an invalid-entry trap reports a zero address.

Only the bench scenarios can show the values themselves. These include the frame number taken from a fetched entry, the entry address as base plus page number after a context switch, the exact cycle of each read and response under several memory latencies, and the boundary between the last in-range page and the first out-of-range page.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_READ  = 2'd2,
    ST_RESP  = 2'd3
  } walk_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_LEN  = 2'b01,
    CAUSE_INV  = 2'b10
  } trap_cause_e;
endpackage

// File: rtl/pt_walker_ctx.sv
module pt_walker_ctx #(
  parameter int MA_W  = 32,
  parameter int LEN_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [MA_W-1:0]  base_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [MA_W-1:0]  base_o,
  output logic [LEN_W-1:0] len_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      len_o  <= '0;
    end else if (load_i) begin
      base_o <= base_i;
      len_o  <= len_i;
    end
  end
endmodule

// File: rtl/pt_walker_pte.sv
module pt_walker_pte #(
  parameter int PTE_W = 32,
  parameter int OFS_W = 12,
  parameter int VLD_B = 0,
  localparam int FRAME_W = PTE_W - OFS_W,
  localparam int PA_W    = FRAME_W + OFS_W
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic             valid_o,
  output logic [PA_W-1:0]  paddr_o
);
  logic [OFS_W-1:0] unused_low;

  assign valid_o    = pte_i[VLD_B];
  assign paddr_o    = {pte_i[PTE_W-1:OFS_W], ofs_i};
  assign unused_low = pte_i[OFS_W-1:0];
endmodule

// File: rtl/pt_walker_fsm.sv
module pt_walker_fsm
  import pt_walker_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFS_W = 12,
  parameter int MA_W  = 32,
  parameter int PA_W  = 32,
  localparam int VPN_W = VA_W - OFS_W,
  localparam int LEN_W = VPN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  output logic             req_ready_o,
  input  logic [MA_W-1:0]  base_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             mem_rd_o,
  output logic [MA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  output logic [OFS_W-1:0] ofs_o,
  input  logic             pte_valid_i,
  input  logic [PA_W-1:0]  pte_paddr_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_trap_o,
  output logic [1:0]       rsp_cause_o
);
  walk_state_e      state_q;
  trap_cause_e      cause_q;
  logic [VA_W-1:0]  vaddr_q;
  logic [VPN_W-1:0] vpn;
  logic             out_of_range;

  assign vpn          = vaddr_q[VA_W-1:OFS_W];
  assign ofs_o        = vaddr_q[OFS_W-1:0];
  assign out_of_range = {1'b0, vpn} >= len_i;

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_rd_o    = (state_q == ST_CHECK) && !out_of_range;
  assign mem_addr_o  = base_i + MA_W'(vpn);
  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_cause_o = cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cause_q     <= CAUSE_NONE;
      vaddr_q     <= '0;
      rsp_paddr_o <= '0;
      rsp_trap_o  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          vaddr_q <= req_vaddr_i;
          state_q <= ST_CHECK;
        end
        ST_CHECK: if (out_of_range) begin
          rsp_paddr_o <= '0;
          rsp_trap_o  <= 1'b1;
          cause_q     <= CAUSE_LEN;
          state_q     <= ST_RESP;
        end else begin
          state_q <= ST_READ;
        end
        ST_READ: if (mem_rvalid_i) begin
          rsp_paddr_o <= pte_valid_i ? pte_paddr_i : '0;
          rsp_trap_o  <= !pte_valid_i;
          cause_q     <= pte_valid_i ? CAUSE_NONE : CAUSE_INV;
          state_q     <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int OFS_W = 12,
  parameter int PTE_W = 32,
  parameter int MA_W  = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ctx_load_i,
  input  logic [MA_W-1:0]         ctx_base_i,
  input  logic [VA_W-OFS_W:0]     ctx_len_i,
  input  logic                    req_valid_i,
  input  logic [VA_W-1:0]         req_vaddr_i,
  output logic                    req_ready_o,
  output logic                    mem_rd_o,
  output logic [MA_W-1:0]         mem_addr_o,
  input  logic                    mem_rvalid_i,
  input  logic [PTE_W-1:0]        mem_rdata_i,
  output logic                    rsp_valid_o,
  output logic [PTE_W-1:0]        rsp_paddr_o,
  output logic                    rsp_trap_o,
  output logic [1:0]              rsp_cause_o
);
  localparam int LEN_W = VA_W - OFS_W + 1;
  localparam int PA_W  = PTE_W;

  logic [MA_W-1:0]  base_q;
  logic [LEN_W-1:0] len_q;
  logic [OFS_W-1:0] cur_ofs;
  logic             pte_valid;
  logic [PA_W-1:0]  pte_paddr;

  pt_walker_ctx #(.MA_W(MA_W), .LEN_W(LEN_W)) u_ctx (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(ctx_load_i),
    .base_i(ctx_base_i), .len_i(ctx_len_i), .base_o(base_q), .len_o(len_q)
  );

  pt_walker_pte #(.PTE_W(PTE_W), .OFS_W(OFS_W)) u_pte (
    .pte_i(mem_rdata_i), .ofs_i(cur_ofs), .valid_o(pte_valid), .paddr_o(pte_paddr)
  );

  pt_walker_fsm #(.VA_W(VA_W), .OFS_W(OFS_W), .MA_W(MA_W), .PA_W(PA_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_vaddr_i (req_vaddr_i),
    .req_ready_o (req_ready_o),
    .base_i      (base_q),
    .len_i       (len_q),
    .mem_rd_o    (mem_rd_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i),
    .ofs_o       (cur_ofs),
    .pte_valid_i (pte_valid),
    .pte_paddr_i (pte_paddr),
    .rsp_valid_o (rsp_valid_o),
    .rsp_paddr_o (rsp_paddr_o),
    .rsp_trap_o  (rsp_trap_o),
    .rsp_cause_o (rsp_cause_o)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int OFS_W = 12,
  parameter int PA_W  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             mem_rd_o,
  input logic             mem_rvalid_i,
  input logic             rsp_valid_o,
  input logic [PA_W-1:0]  rsp_paddr_o,
  input logic             rsp_trap_o,
  input logic [1:0]       rsp_cause_o,
  input logic [OFS_W-1:0] cur_ofs
);
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o)); // R9
  AST_RD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o); // R5
  AST_LEN_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_cause_o == 2'b01) |-> $past(!mem_rd_o)); // R4
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R8
  AST_OFS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_trap_o) |-> (rsp_paddr_o[OFS_W-1:0] == cur_ofs)); // R7
  AST_CAUSE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_trap_o ? ($countones(rsp_cause_o) == 1) : (rsp_cause_o == 2'b00))); // R6
  AST_INV_ZERO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_cause_o == 2'b10) |-> (rsp_paddr_o == '0)); // R6
  AST_STRAY_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && mem_rvalid_i) |=> !rsp_valid_o); // R10
endmodule

bind pt_walker pt_walker_chk #(.OFS_W(OFS_W), .PA_W(PA_W)) u_pt_walker_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .mem_rd_o    (mem_rd_o),
  .mem_rvalid_i(mem_rvalid_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_paddr_o (rsp_paddr_o),
  .rsp_trap_o  (rsp_trap_o),
  .rsp_cause_o (rsp_cause_o),
  .cur_ofs     (cur_ofs)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctx_load_i = 1'b0;
  logic [31:0] ctx_base_i = '0;
  logic [20:0] ctx_len_i = '0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic        req_ready_o, mem_rd_o, rsp_valid_o, rsp_trap_o;
  logic [31:0] mem_addr_o, rsp_paddr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic [1:0]  rsp_cause_o;

  always #4 clk_i = ~clk_i;

  pt_walker u_pt_walker (.*);

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int lat     = 1;
  bit stray_rv = 1'b0;
  int mem_cnt = 0;
  logic [7:0] mem_idx = '0;
  logic [31:0] pt_mem [256];
  logic [31:0] m_base = '0;
  logic [20:0] m_len  = '0;

  typedef struct { int at; logic [31:0] pa; logic trap; logic [1:0] cause; string tag; } rsp_t;
  typedef struct { int at; logic [31:0] addr; } rd_t;
  rsp_t rsp_q[$];
  rd_t  rd_q[$];

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // memory: answers each read strobe after lat cycles
  always @(negedge clk_i) begin
    mem_rvalid_i = stray_rv;
    if (mem_cnt > 0) begin
      mem_cnt--;
      if (mem_cnt == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = pt_mem[mem_idx];
      end
    end
    if (mem_rd_o && rst_ni) begin
      mem_cnt = lat;
      mem_idx = mem_addr_o[7:0];
    end
  end

  // per-cycle comparison against the model's expected reads and responses
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (rd_q.size() > 0 && rd_q[0].at == cyc) begin
        chk("R5 read strobe", {63'd0, mem_rd_o}, 64'd1);
        chk("R5 read address", {32'd0, mem_addr_o}, {32'd0, rd_q[0].addr});
        void'(rd_q.pop_front());
      end else if (mem_rd_o) begin
        chk("R4/R8 unexpected read", 64'd1, 64'd0);
      end
      if (rsp_q.size() > 0 && rsp_q[0].at == cyc) begin
        chk({rsp_q[0].tag, " rsp valid"}, {63'd0, rsp_valid_o}, 64'd1);
        chk({rsp_q[0].tag, " paddr"}, {32'd0, rsp_paddr_o}, {32'd0, rsp_q[0].pa});
        chk({rsp_q[0].tag, " trap/cause"}, {61'd0, rsp_trap_o, rsp_cause_o},
            {61'd0, rsp_q[0].trap, rsp_q[0].cause});
        void'(rsp_q.pop_front());
      end else if (rsp_valid_o) begin
        chk("R9/R10 unexpected response", 64'd1, 64'd0);
      end
    end
  end

  task automatic load_ctx(input logic [31:0] b, input logic [20:0] l);
    ctx_load_i = 1'b1; ctx_base_i = b; ctx_len_i = l;
    @(negedge clk_i);
    ctx_load_i = 1'b0;
    m_base = b; m_len = l;
  endtask

  task automatic model(input logic [31:0] va, input string tag, input int k);
    logic [19:0] vpn;
    logic [31:0] ent;
    rsp_t r;
    vpn = va[31:12];
    r.tag = tag;
    if ({1'b0, vpn} >= m_len) begin
      r.at = k + 2; r.pa = '0; r.trap = 1'b1; r.cause = 2'b01;
    end else begin
      rd_q.push_back('{at: k + 1, addr: m_base + {12'd0, vpn}});
      ent = pt_mem[8'(m_base + {12'd0, vpn})];
      r.at = k + 2 + lat;
      if (ent[0]) begin r.pa = {ent[31:12], va[11:0]}; r.trap = 1'b0; r.cause = 2'b00; end
      else begin r.pa = '0; r.trap = 1'b1; r.cause = 2'b10; end
    end
    rsp_q.push_back(r);
  endtask

  task automatic issue(input logic [31:0] va, input string tag, input bit poke_busy);
    while (!req_ready_o) @(negedge clk_i);
    model(va, tag, cyc);
    req_valid_i = 1'b1; req_vaddr_i = va;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (poke_busy) begin
      chk("R8 ready low while busy", {63'd0, req_ready_o}, 64'd0);
      req_valid_i = 1'b1; req_vaddr_i = va ^ 32'h0000_3000;
      @(negedge clk_i);
      @(negedge clk_i);
      req_valid_i = 1'b0;
    end
    while (rsp_q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
    chk("R9 ready after response", {63'd0, req_ready_o}, 64'd1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++)
      pt_mem[i] = {20'(i * 37 + 5), 11'd0, (i % 5) != 0};
    @(negedge clk_i);
    chk("R1 ready in reset", {63'd0, req_ready_o}, 64'd1);
    chk("R1 no rsp in reset", {63'd0, rsp_valid_o}, 64'd0);
    chk("R1 no read in reset", {63'd0, mem_rd_o}, 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    issue(32'h0000_0123, "R1", 1'b0);           // length 0 after reset

    load_ctx(32'd16, 21'd40);
    lat = 1; issue(32'h0000_1abc, "R2", 1'b0);  // vpn 1
    lat = 3; issue(32'h0000_5fff, "R7", 1'b0);  // vpn 5
    lat = 2; issue(32'h0002_7001, "R4", 1'b0);  // vpn 39 = len-1, in range
    issue(32'h0002_8000, "R4", 1'b0);           // vpn 40 = len, trap
    issue(32'hffff_f000, "R4", 1'b0);           // max vpn, trap
    lat = 4; issue(32'h0000_4321, "R6", 1'b0);  // vpn 4 -> entry 20, invalid
    lat = 5; issue(32'h0000_2468, "R8", 1'b1);  // poke while busy

    stray_rv = 1'b1;
    @(negedge clk_i);
    stray_rv = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk("R10 stray rvalid ignored", {63'd0, rsp_valid_o}, 64'd0);
    end

    load_ctx(32'd100, 21'd40);                  // base only changes
    lat = 1; issue(32'h0000_1abc, "R3", 1'b0);
    lat = 6; issue(32'h0000_3777, "R3", 1'b0);
    load_ctx(32'd100, 21'd2);
    issue(32'h0000_3777, "R3", 1'b0);           // vpn 3 now beyond length

    repeat (3) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule